// File: doc/BRIEF.md
# SLC-96 Receive Message Extractor

This block sits behind a T1 framer that has already found D4 superframe alignment. It receives one framing bit per frame together with a frame strobe, and a flag that is high when that bit belongs to an even, Fs-type frame position. The Ft/Fs cross-coupling is resolved upstream, so only the Fs-position bits concern this block. A multiframe of 72 frames is made of six 12-frame superframes. Half of its framing bits are Ft bits. The other 36 sit in Fs positions. Twelve of these 36 form a fixed alignment word, and the remaining 24 carry message data: concentrator, spoiler, maintenance and alarm fields.

The extractor keeps a window of the last 36 Fs-position bits and hunts for the alignment word at its oldest end. When it finds the word, it declares alignment. From then on it counts Fs bits so that it knows each multiframe boundary. At every boundary where the word is present again, it copies the 24 message bits into three 8-bit message registers and sets a sticky update flag that software clears by writing a one. The registers then hold still for a full multiframe (9 ms of line time), which gives software time to read them. When the word is missing at two boundaries in a row, the block drops alignment and hunts again.

Top module: `slc96_rx_extractor`

## Requirements
- R1: After reset the three message registers read zero, the update flag is clear and `aligned` is low.
- R2: Only a frame strobe with `fs_pos` high, while the block is active, feeds the search window. Strobes with `fs_pos` low (Ft positions) and cycles without a strobe have no effect.
- R3: Alignment is declared when, of the last 36 Fs-position bits, the 12 oldest equal the word 0,0,0,1,1,1,0,0,0,1,1,1 in arrival order. `aligned` rises one clock after the strobe that completes the word plus 36 bits.
- R4: The message registers load and the flag sets only at a boundary where the alignment word is present in the multiframe just received. A multiframe whose word is corrupted changes neither the registers nor the flag.
- R5: On detection, and at every later boundary whose word matches, message bit k (the k-th Fs bit after the 12 alignment bits, k = 0..23) goes to register k/8, bit k mod 8, where register 0 is `msg_a`, register 1 is `msg_b` and register 2 is `msg_c`. In the same step the flag sets. Both are visible one clock after the last strobe of the multiframe.
- R6: Between two updates the message registers do not change, including during the whole following multiframe.
- R7: With `enable` low or `d4_mode` low, the registers hold their contents and the flag never sets. Alignment, the search window and the miss count are cleared.
- R8: One multiframe with a bad word keeps alignment. A second consecutive one drops `aligned` at that boundary.
- R9: The flag is write-1-to-clear through `flag_clr`. An update in the same cycle as a clear wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Extractor enable |
| d4_mode | input | 1 | High when the framer runs D4 superframe mode |
| frame_strobe | input | 1 | One-cycle pulse, one per received frame |
| fbit | input | 1 | Framing bit of the current frame |
| fs_pos | input | 1 | High when the framing bit is in an Fs position |
| flag_clr | input | 1 | Write-1-to-clear pulse for the update flag |
| msg_a | output | 8 | Message bits 0..7 |
| msg_b | output | 8 | Message bits 8..15 |
| msg_c | output | 8 | Message bits 16..23 |
| upd_flag | output | 1 | Sticky update flag |
| aligned | output | 1 | Multiframe alignment held |

## Verification
Every result of this block comes from a single register stage after the strobe that causes it. The message registers, the update flag and `aligned` all change on the clock edge that samples the 36th Fs bit of a multiframe, and a clear takes effect on the edge that samples `flag_clr`. The bench drives each frame on a falling edge, drops the strobe on the next falling edge, and reads the outputs only after that, so each check sits one edge after its cause. Stability is checked frame by frame through the following multiframe, up to the strobe that may legally change the registers.

// File: rtl/slc96_pkg.sv
package slc96_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_t;

  localparam int unsigned FS_PER_MF  = 36;
  localparam int unsigned SYNC_LEN   = 12;
  localparam logic [11:0] SYNC_WORD  = 12'hE38;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned REG_COUNT  = 3;
  localparam int unsigned MISS_DROP  = 2;
endpackage

// File: rtl/slc96_fs_window.sv
module slc96_fs_window #(
  parameter int unsigned MF_BITS   = 36,
  parameter int unsigned SYNC_BITS = 12,
  parameter logic [SYNC_BITS-1:0] PATTERN = 12'hE38
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act,
  input  logic               fs_tick,
  input  logic               fbit,
  output logic               hit,
  output logic [MF_BITS-1:0] window
);
  localparam int unsigned FW = $clog2(MF_BITS + 1);
  localparam logic [FW-1:0] FULL   = FW'(MF_BITS);
  localparam logic [FW-1:0] ALMOST = FW'(MF_BITS - 1);

  logic [MF_BITS-1:0] sr_q;
  logic [FW-1:0]      fill_q;

  // Newest bit enters at the top, oldest sits at bit 0.
  always_comb begin
    window = sr_q;
    if (fs_tick) window = {fbit, sr_q[MF_BITS-1:1]};
  end

  assign hit = fs_tick && (fill_q >= ALMOST) && (window[SYNC_BITS-1:0] == PATTERN);

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (fs_tick) begin
      sr_q <= window;
      if (fill_q != FULL) fill_q <= fill_q + FW'(1);
    end
  end

  AST_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FULL); // R3
endmodule

// File: rtl/slc96_sync_fsm.sv
module slc96_sync_fsm
  import slc96_pkg::*;
#(
  parameter int unsigned MF_BITS    = 36,
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic fs_tick,
  input  logic hit,
  output logic publish,
  output logic locked
);
  localparam int unsigned PW = $clog2(MF_BITS);
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(MF_BITS - 1);
  localparam logic [MW-1:0] MLIM = MW'(MISS_LIMIT);

  sync_state_t state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    miss_d  = miss_q;
    publish = 1'b0;
    if (!act) begin
      state_d = ST_HUNT;
      pos_d   = '0;
      miss_d  = '0;
    end else if (fs_tick) begin
      unique case (state_q)
        ST_HUNT: begin
          if (hit) begin
            state_d = ST_LOCK;
            pos_d   = '0;
            miss_d  = '0;
            publish = 1'b1;
          end
        end
        ST_LOCK: begin
          if (pos_q == LAST) begin
            pos_d = '0;
            if (hit) begin
              publish = 1'b1;
              miss_d  = '0;
            end else if (miss_q + MW'(1) >= MLIM) begin
              state_d = ST_HUNT;
              miss_d  = '0;
            end else begin
              miss_d = miss_q + MW'(1);
            end
          end else begin
            pos_d = pos_q + PW'(1);
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      miss_q  <= miss_d;
    end
  end

  assign locked = (state_q == ST_LOCK);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST); // R8
  AST_MISS_RANGE: assert property (@(posedge clk) disable iff (rst)
    miss_q < MLIM); // R8
  AST_IDLE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    !act |=> !locked); // R7
endmodule

// File: rtl/slc96_msg_bank.sv
module slc96_msg_bank #(
  parameter int unsigned MF_BITS   = 36,
  parameter int unsigned SYNC_BITS = 12,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned REGS      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [MF_BITS-1:0]    window,
  input  logic                  clr,
  output logic [REGS*REG_W-1:0] msg_flat,
  output logic                  flag
);
  localparam int unsigned MSG_BITS = MF_BITS - SYNC_BITS;
  localparam int unsigned TOTAL    = REGS * REG_W;

  logic [TOTAL-1:0] nxt;

  // Message bit k lands in register k/REG_W, bit k%REG_W; spare bits read zero.
  for (genvar r = 0; r < REGS; r++) begin : g_reg
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      localparam int unsigned K = r * REG_W + b;
      if (K < MSG_BITS) begin : g_used
        assign nxt[K] = window[SYNC_BITS + K];
      end else begin : g_spare
        assign nxt[K] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_flat <= '0;
      flag     <= 1'b0;
    end else begin
      if (load) msg_flat <= nxt;
      if (load)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
    load |=> flag); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> !flag); // R9
endmodule

// File: rtl/slc96_rx_extractor.sv
module slc96_rx_extractor
  import slc96_pkg::*;
#(
  parameter int unsigned MF_BITS    = FS_PER_MF,
  parameter int unsigned SYNC_BITS  = SYNC_LEN,
  parameter logic [SYNC_BITS-1:0] PATTERN = SYNC_WORD,
  parameter int unsigned MSG_W      = REG_W,
  parameter int unsigned MISS_LIMIT = MISS_DROP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             d4_mode,
  input  logic             frame_strobe,
  input  logic             fbit,
  input  logic             fs_pos,
  input  logic             flag_clr,
  output logic [MSG_W-1:0] msg_a,
  output logic [MSG_W-1:0] msg_b,
  output logic [MSG_W-1:0] msg_c,
  output logic             upd_flag,
  output logic             aligned
);
  localparam int unsigned NREG = REG_COUNT;

  logic                    act, fs_tick, hit, publish;
  logic [MF_BITS-1:0]      window;
  logic [NREG*MSG_W-1:0]   msg_flat;

  assign act     = enable && d4_mode;
  assign fs_tick = act && frame_strobe && fs_pos;

  slc96_fs_window #(
    .MF_BITS(MF_BITS), .SYNC_BITS(SYNC_BITS), .PATTERN(PATTERN)
  ) u_window (
    .clk(clk), .rst(rst), .act(act), .fs_tick(fs_tick), .fbit(fbit),
    .hit(hit), .window(window)
  );

  slc96_sync_fsm #(
    .MF_BITS(MF_BITS), .MISS_LIMIT(MISS_LIMIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .act(act), .fs_tick(fs_tick), .hit(hit),
    .publish(publish), .locked(aligned)
  );

  slc96_msg_bank #(
    .MF_BITS(MF_BITS), .SYNC_BITS(SYNC_BITS), .REG_W(MSG_W), .REGS(NREG)
  ) u_bank (
    .clk(clk), .rst(rst), .load(publish), .window(window), .clr(flag_clr),
    .msg_flat(msg_flat), .flag(upd_flag)
  );

  assign msg_a = msg_flat[0*MSG_W +: MSG_W];
  assign msg_b = msg_flat[1*MSG_W +: MSG_W];
  assign msg_c = msg_flat[2*MSG_W +: MSG_W];

  AST_PUB_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    publish |-> hit); // R4
  AST_STROBE_GATE: assert property (@(posedge clk) disable iff (rst)
    !(frame_strobe && fs_pos) |-> !publish); // R2
  AST_IDLE_NO_PUB: assert property (@(posedge clk) disable iff (rst)
    !(enable && d4_mode) |-> !publish); // R7
  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (rst)
    !publish |=> $stable({msg_c, msg_b, msg_a})); // R6
endmodule

// File: tb/slc96_rx_extractor_bench.sv
module slc96_rx_extractor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1, d4_mode = 1'b1;
  logic frame_strobe = 1'b0, fbit = 1'b0, fs_pos = 1'b0, flag_clr = 1'b0;
  logic [7:0] msg_a, msg_b, msg_c;
  logic upd_flag, aligned;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [11:0] PAT = 12'hE38;

  always #2 clk = ~clk;

  slc96_rx_extractor u_slc96_rx_extractor (
    .clk(clk), .rst(rst), .enable(enable), .d4_mode(d4_mode),
    .frame_strobe(frame_strobe), .fbit(fbit), .fs_pos(fs_pos),
    .flag_clr(flag_clr), .msg_a(msg_a), .msg_b(msg_b), .msg_c(msg_c),
    .upd_flag(upd_flag), .aligned(aligned)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic tick_frame(input logic b, input logic fs, input logic clr_v);
    @(negedge clk);
    frame_strobe = 1'b1; fbit = b; fs_pos = fs; flag_clr = clr_v;
    @(negedge clk);
    frame_strobe = 1'b0; flag_clr = 1'b0; fbit = ~b; fs_pos = 1'b1;
  endtask

  // One 72-frame multiframe: Ft frames carry 1, Fs frames carry sync word then message.
  task automatic send_mf(input logic [23:0] m, input bit bad, input bit clr_last,
                         input bit chk_stable);
    logic [35:0] fsb;
    logic [23:0] snap;
    bit stable;
    fsb = {m, PAT};
    if (bad) fsb[0] = ~fsb[0];
    snap = {msg_c, msg_b, msg_a};
    stable = 1'b1;
    for (int f = 0; f < 72; f++) begin
      if (f % 2 == 0) tick_frame(1'b1, 1'b0, 1'b0);
      else tick_frame(fsb[f/2], 1'b1, clr_last && (f == 71));
      if (f < 71 && {msg_c, msg_b, msg_a} != snap) stable = 1'b0;
    end
    if (chk_stable) check(stable, "R6 registers held through multiframe", {8'd0, snap}, {8'd0, snap});
  endtask

  task automatic do_clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(upd_flag == 1'b0, "R9 write-1 clears flag", upd_flag, 0);
  endtask

  task automatic t_reset();
    check({msg_c, msg_b, msg_a} == 24'd0, "R1 message regs zero", {msg_c, msg_b, msg_a}, 0);
    check(upd_flag == 1'b0, "R1 flag clear", upd_flag, 0);
    check(aligned == 1'b0, "R1 not aligned", aligned, 0);
  endtask

  task automatic t_first_lock();
    send_mf(24'hA5C31E, 1'b0, 1'b0, 1'b0);
    check(aligned == 1'b1, "R3 alignment found (R2 Ft bits ignored)", aligned, 1);
    check(upd_flag == 1'b1, "R5 flag set on detection", upd_flag, 1);
    check({msg_c, msg_b, msg_a} == 24'hA5C31E, "R5 bit placement",
          {msg_c, msg_b, msg_a}, 24'hA5C31E);
  endtask

  task automatic t_update_and_clear();
    do_clear();
    send_mf(24'h3C0FF1, 1'b0, 1'b1, 1'b1);
    check(upd_flag == 1'b1, "R9 update beats same-cycle clear", upd_flag, 1);
    check({msg_c, msg_b, msg_a} == 24'h3C0FF1, "R5 boundary update",
          {msg_c, msg_b, msg_a}, 24'h3C0FF1);
  endtask

  task automatic t_single_miss();
    do_clear();
    send_mf(24'h777777, 1'b1, 1'b0, 1'b0);
    check(upd_flag == 1'b0, "R4 bad word leaves flag clear", upd_flag, 0);
    check({msg_c, msg_b, msg_a} == 24'h3C0FF1, "R4 bad word leaves regs",
          {msg_c, msg_b, msg_a}, 24'h3C0FF1);
    check(aligned == 1'b1, "R8 one miss keeps alignment", aligned, 1);
    send_mf(24'h081422, 1'b0, 1'b0, 1'b1);
    check({msg_c, msg_b, msg_a} == 24'h081422, "R8 recovers after one miss",
          {msg_c, msg_b, msg_a}, 24'h081422);
  endtask

  task automatic t_double_miss();
    do_clear();
    send_mf(24'hFFFFFF, 1'b1, 1'b0, 1'b0);
    check(aligned == 1'b1, "R8 first miss still aligned", aligned, 1);
    send_mf(24'h000000, 1'b1, 1'b0, 1'b0);
    check(aligned == 1'b0, "R8 second miss drops alignment", aligned, 0);
    check(upd_flag == 1'b0, "R4 no flag after misses", upd_flag, 0);
    check({msg_c, msg_b, msg_a} == 24'h081422, "R4 regs kept after misses",
          {msg_c, msg_b, msg_a}, 24'h081422);
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    send_mf(24'h123456, 1'b0, 1'b0, 1'b0);
    check(upd_flag == 1'b0, "R7 disabled: no flag", upd_flag, 0);
    check(aligned == 1'b0, "R7 disabled: no alignment", aligned, 0);
    check({msg_c, msg_b, msg_a} == 24'h081422, "R7 disabled: regs held",
          {msg_c, msg_b, msg_a}, 24'h081422);
    enable = 1'b1; d4_mode = 1'b0;
    send_mf(24'h654321, 1'b0, 1'b0, 1'b0);
    check(upd_flag == 1'b0, "R7 non-D4: no flag", upd_flag, 0);
    check({msg_c, msg_b, msg_a} == 24'h081422, "R7 non-D4: regs held",
          {msg_c, msg_b, msg_a}, 24'h081422);
    d4_mode = 1'b1;
    send_mf(24'hC0FFEE, 1'b0, 1'b0, 1'b0);
    check(aligned == 1'b1, "R3 relock after re-enable", aligned, 1);
    check({msg_c, msg_b, msg_a} == 24'hC0FFEE, "R5 relock loads message",
          {msg_c, msg_b, msg_a}, 24'hC0FFEE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_lock();
    t_update_and_clear();
    t_single_miss();
    t_double_miss();
    t_disabled();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog expired", cyc, 20000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule